// File: doc/BRIEF.md
# Time-of-Day Counter with Register Interface

This block keeps wall-clock time as a 48-bit seconds count plus a 30-bit nanoseconds count. On every edge of its reference clock it adds a programmable fixed-point step to the time. The step has 16 fractional bits, and a 16-bit fractional accumulator carries the sub-nanosecond remainder from one cycle to the next. Two correction mechanisms sit on top of the nominal step. A counted window substitutes an alternate step for a set number of cycles, which slews the time offset smoothly. A drift injector adds a small fractional amount once every N cycles, which trims the rate below the resolution of the step.

Software reaches the block through a 32-bit register port with separate read and write strobes. Reading the nanoseconds register freezes the seconds value, so the two seconds registers that follow return a time that matches the nanoseconds value already read. Writes to the seconds registers are only staged. The nanoseconds write commits the staged seconds and the new nanoseconds together, in one cycle.

Top module: `time_of_day_clock`

## Requirements
- R1: Reset clears the time, the seconds snapshot, the alternate-cycle count, DRIFT_STEP and DRIFT_GAP. It loads STEP with the parameter NOMINAL_STEP.
- R2: A write to SEC_LO (address 0x14, all 32 bits, seconds[31:0]) or to SEC_HI (address 0x18, bits 15:0 hold seconds[47:32]) is only staged. The live time goes on advancing as if no write had occurred.
- R3: A write to TIME_NS (address 0x10, bits 29:0) loads the staged seconds and the written nanoseconds into the live time at that same edge. It clears the fractional accumulator and takes the place of that cycle's increment.
- R4: STEP (address 0x20) is 20 bits, with bits 19:16 the whole nanoseconds and bits 15:0 the fraction. It is added once per cycle. It reads back in bits 19:0, with the upper bits zero.
- R5: The sub-nanosecond part of each addition is accumulated in 16 fractional bits, and its carries go into the nanosecond count.
- R6: When the nanoseconds value reaches or passes 1,000,000,000, the block subtracts 1,000,000,000 and adds one to the seconds, including the carry from seconds[31:0] into seconds[47:32].
- R7: A read of TIME_NS returns the live nanoseconds and captures the live seconds. Later reads of SEC_LO and SEC_HI return the captured value. Read data appears on rdata in the cycle after the rd_en cycle.
- R8: A nonzero write to ALT_CYCLES (address 0x28) makes the edges after the write add ALT_STEP (address 0x24, same format as STEP) for that many cycles. ALT_CYCLES reads back the remaining count, one less per cycle, and reads zero when the window is over. Writing zero cancels a running window.
- R9: RATE_HZ (address 0x00) is read-only and returns the parameter REF_HZ. Writes to it change nothing.
- R10: DRIFT_STEP (address 0x2C, 16 fractional bits) is added once every DRIFT_GAP (address 0x30) cycles, on top of the step. A write to DRIFT_GAP restarts the interval, so the first addition falls on the DRIFT_GAP-th edge after that write. A DRIFT_GAP of zero disables the addition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; time advances on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| time_sec | output | 48 | Live seconds |
| time_ns | output | 30 | Live nanoseconds |

## Verification
The bench builds the block with REF_HZ set to 100,000,000 and NOMINAL_STEP set to 0xA0000, a whole 10 ns per cycle. With these values every expected time is a short sum that the bench can compute, and a commit just below 1,000,000,000 reaches the seconds rollover within one or two cycles. Steps of 1.5 ns and 3 ns, and a 0.5 ns drift amount every second cycle, drive the fractional accumulator, the alternate window and the drift injector along paths that are known exactly.

// File: rtl/tod_pkg.sv
package tod_pkg;

    // Fixed field widths of the time value
    localparam int SEC_W  = 48;
    localparam int NS_W   = 30;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int SEC_LO_W = 32;

    localparam int unsigned NS_PER_SEC = 1_000_000_000;

    // Register byte addresses
    localparam logic [ADDR_W-1:0] RA_RATE_HZ     = 8'h00;
    localparam logic [ADDR_W-1:0] RA_TIME_NS     = 8'h10;
    localparam logic [ADDR_W-1:0] RA_SEC_LO      = 8'h14;
    localparam logic [ADDR_W-1:0] RA_SEC_HI      = 8'h18;
    localparam logic [ADDR_W-1:0] RA_STEP        = 8'h20;
    localparam logic [ADDR_W-1:0] RA_ALT_STEP    = 8'h24;
    localparam logic [ADDR_W-1:0] RA_ALT_CYCLES  = 8'h28;
    localparam logic [ADDR_W-1:0] RA_DRIFT_STEP  = 8'h2C;
    localparam logic [ADDR_W-1:0] RA_DRIFT_GAP   = 8'h30;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } tod_time_t;

    typedef enum logic [0:0] {
        SRC_NOMINAL = 1'b0,
        SRC_ALT     = 1'b1
    } step_src_e;

    // Fold a raw nanosecond sum back into one second
    function automatic logic [NS_W-1:0] fold_ns(input logic [NS_W:0] raw, input logic wrap);
        logic [NS_W:0] t;
        t = wrap ? raw - (NS_W+1)'(NS_PER_SEC) : raw;
        return t[NS_W-1:0];
    endfunction

endpackage

// File: rtl/tod_step_sel.sv
module tod_step_sel
    import tod_pkg::*;
#(
    parameter int STEP_W  = 20,
    parameter int CNT_W   = 20,
    parameter int DRIFT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STEP_W-1:0]  step,
    input  logic [STEP_W-1:0]  alt_step,
    input  logic               alt_load,
    input  logic [CNT_W-1:0]   alt_load_val,
    input  logic [DRIFT_W-1:0] drift_step,
    input  logic [DRIFT_W-1:0] drift_gap,
    input  logic               gap_restart,
    output logic [CNT_W-1:0]   alt_left,
    output logic               drift_fire,
    output logic [STEP_W:0]    incr
);
    localparam int INC_W = STEP_W + 1;

    step_src_e          src;
    logic [DRIFT_W-1:0] gap_cnt;
    logic [STEP_W-1:0]  base;

    // Alternate-step window countdown; a write reloads or cancels it
    always_ff @(posedge clk) begin
        if (rst) begin
            alt_left <= '0;
        end else if (alt_load) begin
            alt_left <= alt_load_val;
        end else if (alt_left != '0) begin
            alt_left <= alt_left - CNT_W'(1);
        end
    end

    // Drift interval timer
    always_ff @(posedge clk) begin
        if (rst || gap_restart || drift_gap == '0) begin
            gap_cnt <= '0;
        end else if (drift_fire) begin
            gap_cnt <= '0;
        end else begin
            gap_cnt <= gap_cnt + DRIFT_W'(1);
        end
    end

    always_comb begin
        drift_fire = (drift_gap != '0) && (gap_cnt == drift_gap - DRIFT_W'(1));
        src        = (alt_left != '0) ? SRC_ALT : SRC_NOMINAL;
        base       = (src == SRC_ALT) ? alt_step : step;
        incr       = INC_W'(base) + (drift_fire ? INC_W'(drift_step) : INC_W'(0));
    end

endmodule

// File: rtl/tod_time_acc.sv
module tod_time_acc
    import tod_pkg::*;
#(
    parameter int STEP_W = 20,
    parameter int FRAC_W = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [STEP_W:0] incr,
    input  logic          commit,
    input  tod_time_t     commit_time,
    output tod_time_t     now_time
);
    localparam int ACC_W = NS_W + FRAC_W + 1;

    logic [FRAC_W-1:0] frac;
    logic [ACC_W-1:0]  sum;
    logic [NS_W:0]     ns_raw;
    logic              wrap;
    tod_time_t         next_time;
    logic [FRAC_W-1:0] next_frac;

    always_comb begin
        sum       = {1'b0, now_time.ns, frac} + ACC_W'(incr);
        ns_raw    = sum[ACC_W-1:FRAC_W];
        next_frac = sum[FRAC_W-1:0];
        wrap      = ns_raw >= (NS_W+1)'(NS_PER_SEC);
        next_time.ns  = fold_ns(ns_raw, wrap);
        next_time.sec = now_time.sec + (wrap ? SEC_W'(1) : SEC_W'(0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now_time <= '0;
            frac     <= '0;
        end else if (commit) begin
            now_time <= commit_time;
            frac     <= '0;
        end else begin
            now_time <= next_time;
            frac     <= next_frac;
        end
    end

endmodule

// File: rtl/tod_regbank.sv
module tod_regbank
    import tod_pkg::*;
#(
    parameter int unsigned REF_HZ       = 156_250_000,
    parameter int unsigned NOMINAL_STEP = 'h66666,
    parameter int STEP_W  = 20,
    parameter int CNT_W   = 20,
    parameter int DRIFT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  tod_time_t          now_time,
    input  logic [CNT_W-1:0]   alt_left,
    output logic [STEP_W-1:0]  step,
    output logic [STEP_W-1:0]  alt_step,
    output logic               alt_load,
    output logic [CNT_W-1:0]   alt_load_val,
    output logic [DRIFT_W-1:0] drift_step,
    output logic [DRIFT_W-1:0] drift_gap,
    output logic               gap_restart,
    output logic               commit,
    output tod_time_t          commit_time,
    output logic [SEC_W-1:0]   stage_sec,
    output logic [SEC_W-1:0]   snap_sec
);
    localparam int HI_W = SEC_W - SEC_LO_W;

    logic wr_hit_ns, wr_hit_hi, wr_hit_lo, rd_hit_ns;

    always_comb begin
        wr_hit_ns   = wr_en && addr == RA_TIME_NS;
        wr_hit_hi   = wr_en && addr == RA_SEC_HI;
        wr_hit_lo   = wr_en && addr == RA_SEC_LO;
        rd_hit_ns   = rd_en && addr == RA_TIME_NS;
        alt_load    = wr_en && addr == RA_ALT_CYCLES;
        gap_restart = wr_en && addr == RA_DRIFT_GAP;
        alt_load_val = wdata[CNT_W-1:0];
        commit          = wr_hit_ns;
        commit_time.sec = stage_sec;
        commit_time.ns  = wdata[NS_W-1:0];
    end

    // Staging of seconds, control registers
    always_ff @(posedge clk) begin
        if (rst) begin
            stage_sec  <= '0;
            step       <= STEP_W'(NOMINAL_STEP);
            alt_step   <= '0;
            drift_step <= '0;
            drift_gap  <= '0;
        end else if (wr_en) begin
            if (wr_hit_hi) stage_sec[SEC_W-1:SEC_LO_W] <= wdata[HI_W-1:0];
            if (wr_hit_lo) stage_sec[SEC_LO_W-1:0]     <= wdata;
            if (addr == RA_STEP)        step       <= wdata[STEP_W-1:0];
            if (addr == RA_ALT_STEP)    alt_step   <= wdata[STEP_W-1:0];
            if (addr == RA_DRIFT_STEP)  drift_step <= wdata[DRIFT_W-1:0];
            if (gap_restart)            drift_gap  <= wdata[DRIFT_W-1:0];
        end
    end

    // Snapshot of seconds on a nanoseconds read
    always_ff @(posedge clk) begin
        if (rst) begin
            snap_sec <= '0;
        end else if (rd_hit_ns) begin
            snap_sec <= now_time.sec;
        end
    end

    // Registered read mux
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (addr)
                RA_RATE_HZ:    rdata <= DATA_W'(REF_HZ);
                RA_TIME_NS:    rdata <= DATA_W'(now_time.ns);
                RA_SEC_LO:     rdata <= snap_sec[SEC_LO_W-1:0];
                RA_SEC_HI:     rdata <= DATA_W'(snap_sec[SEC_W-1:SEC_LO_W]);
                RA_STEP:       rdata <= DATA_W'(step);
                RA_ALT_STEP:   rdata <= DATA_W'(alt_step);
                RA_ALT_CYCLES: rdata <= DATA_W'(alt_left);
                RA_DRIFT_STEP: rdata <= DATA_W'(drift_step);
                RA_DRIFT_GAP:  rdata <= DATA_W'(drift_gap);
                default:       rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/time_of_day_clock.sv
module time_of_day_clock
    import tod_pkg::*;
#(
    parameter int unsigned REF_HZ       = 156_250_000,
    parameter int unsigned NOMINAL_STEP = 'h66666,
    parameter int STEP_W  = 20,
    parameter int FRAC_W  = 16,
    parameter int CNT_W   = 20,
    parameter int DRIFT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [47:0]       time_sec,
    output logic [29:0]       time_ns
);
    tod_time_t          now_time;
    tod_time_t          commit_time;
    logic               commit;
    logic [STEP_W-1:0]  step, alt_step;
    logic               alt_load, gap_restart, drift_fire;
    logic [CNT_W-1:0]   alt_load_val, alt_left;
    logic [DRIFT_W-1:0] drift_step, drift_gap;
    logic [STEP_W:0]    incr;
    logic [SEC_W-1:0]   stage_sec, snap_sec;

    tod_regbank #(
        .REF_HZ(REF_HZ), .NOMINAL_STEP(NOMINAL_STEP),
        .STEP_W(STEP_W), .CNT_W(CNT_W), .DRIFT_W(DRIFT_W)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .now_time(now_time), .alt_left(alt_left),
        .step(step), .alt_step(alt_step),
        .alt_load(alt_load), .alt_load_val(alt_load_val),
        .drift_step(drift_step), .drift_gap(drift_gap),
        .gap_restart(gap_restart),
        .commit(commit), .commit_time(commit_time),
        .stage_sec(stage_sec), .snap_sec(snap_sec)
    );

    tod_step_sel #(
        .STEP_W(STEP_W), .CNT_W(CNT_W), .DRIFT_W(DRIFT_W)
    ) u_step (
        .clk(clk), .rst(rst),
        .step(step), .alt_step(alt_step),
        .alt_load(alt_load), .alt_load_val(alt_load_val),
        .drift_step(drift_step), .drift_gap(drift_gap),
        .gap_restart(gap_restart),
        .alt_left(alt_left), .drift_fire(drift_fire), .incr(incr)
    );

    tod_time_acc #(
        .STEP_W(STEP_W), .FRAC_W(FRAC_W)
    ) u_acc (
        .clk(clk), .rst(rst), .incr(incr),
        .commit(commit), .commit_time(commit_time),
        .now_time(now_time)
    );

    assign time_sec = now_time.sec;
    assign time_ns  = now_time.ns;

endmodule

// File: rtl/tod_clock_checker.sv
module tod_clock_checker
    import tod_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int DRIFT_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [NS_W-1:0]    commit_ns,
    input logic [SEC_W-1:0]   time_sec,
    input logic [NS_W-1:0]    time_ns,
    input logic [SEC_W-1:0]   stage_sec,
    input logic [SEC_W-1:0]   snap_sec,
    input logic [CNT_W-1:0]   alt_left,
    input logic [DRIFT_W-1:0] drift_gap,
    input logic               drift_fire
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (time_sec == '0 && time_ns == '0 && alt_left == '0 && snap_sec == '0));

    assert_stage_only_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == RA_SEC_LO || addr == RA_SEC_HI))
        |=> (time_sec == $past(time_sec) || time_sec == $past(time_sec) + SEC_W'(1)));

    assert_commit_load_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == RA_TIME_NS)
        |=> (time_sec == $past(stage_sec) && time_ns == $past(commit_ns)));

    assert_ns_range_R6: assert property (@(posedge clk) disable iff (rst)
        (time_ns < NS_W'(NS_PER_SEC) && !(wr_en && addr == RA_TIME_NS))
        |=> time_ns < NS_W'(NS_PER_SEC));

    assert_sec_step_R6: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == RA_TIME_NS)
        |=> (time_sec == $past(time_sec) || time_sec == $past(time_sec) + SEC_W'(1)));

    assert_snap_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && addr == RA_TIME_NS) |=> $stable(snap_sec));

    assert_alt_countdown_R8: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && addr == RA_ALT_CYCLES) && alt_left != '0)
        |=> alt_left == $past(alt_left) - CNT_W'(1));

    assert_drift_off_R10: assert property (@(posedge clk) disable iff (rst)
        (drift_gap == '0) |-> !drift_fire);

endmodule

bind time_of_day_clock tod_clock_checker #(
    .CNT_W(CNT_W), .DRIFT_W(DRIFT_W)
) u_checker (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .commit_ns(wdata[29:0]), .time_sec(time_sec), .time_ns(time_ns),
    .stage_sec(stage_sec), .snap_sec(snap_sec), .alt_left(alt_left),
    .drift_gap(drift_gap), .drift_fire(drift_fire)
);

// File: tb/time_of_day_clock_test.sv
module time_of_day_clock_test;
    import tod_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int unsigned BENCH_HZ   = 100_000_000;
    localparam int unsigned BENCH_STEP = 'hA0000;   // 10 ns per cycle

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [47:0] time_sec;
    logic [29:0] time_ns;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    time_of_day_clock #(.REF_HZ(BENCH_HZ), .NOMINAL_STEP(BENCH_STEP)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .time_sec(time_sec), .time_ns(time_ns)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // All tasks enter and leave at a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_time(input logic [47:0] s, input logic [29:0] ns);
        wr(RA_SEC_HI, {16'h0, s[47:32]});
        wr(RA_SEC_LO, s[31:0]);
        wr(RA_TIME_NS, {2'b0, ns});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 sec after reset", 64'(time_sec), 64'd0);
        chk("R1 ns after reset", 64'(time_ns), 64'd0);
        rd(RA_STEP, d);        chk("R1 step nominal", 64'(d), 64'(BENCH_STEP));
        rd(RA_ALT_CYCLES, d);  chk("R1 alt cycles", 64'(d), 64'd0);
        rd(RA_DRIFT_STEP, d);  chk("R1 drift step", 64'(d), 64'd0);
        rd(RA_DRIFT_GAP, d);   chk("R1 drift gap", 64'(d), 64'd0);
        rd(RA_SEC_LO, d);      chk("R1 snapshot", 64'(d), 64'd0);
        rd(RA_RATE_HZ, d);     chk("R9 rate", 64'(d), 64'(BENCH_HZ));
    endtask

    task automatic t_commit_stage();
        set_time(48'd5, 30'd100);
        chk("R3 commit sec", 64'(time_sec), 64'd5);
        chk("R3 commit ns", 64'(time_ns), 64'd100);
        idle(7);
        chk("R4 step 10ns x7", 64'(time_ns), 64'd170);
        wr(RA_SEC_HI, 32'd7);
        chk("R2 hi staged only sec", 64'(time_sec), 64'd5);
        chk("R2 hi staged only ns", 64'(time_ns), 64'd180);
        wr(RA_SEC_LO, 32'd9);
        chk("R2 lo staged only sec", 64'(time_sec), 64'd5);
        wr(RA_TIME_NS, 32'd0);
        chk("R3 commit staged", 64'(time_sec), 64'h7_0000_0009);
        chk("R3 commit ns zero", 64'(time_ns), 64'd0);
    endtask

    task automatic t_step_readback();
        logic [31:0] d;
        wr(RA_STEP, 32'hFFFF_FFFF);
        rd(RA_STEP, d);
        chk("R4 step width", 64'(d), 64'hF_FFFF);
        wr(RA_STEP, BENCH_STEP);
    endtask

    task automatic t_fraction();
        logic [63:0] acc = 0;
        wr(RA_STEP, 32'h18000);        // 1.5 ns
        wr(RA_TIME_NS, 32'd0);
        for (int k = 1; k <= 5; k++) begin
            idle(1);
            acc += 64'h18000;
            chk("R5 fractional carry", 64'(time_ns), acc >> 16);
        end
        wr(RA_TIME_NS, 32'd0);         // half a ns pending is dropped
        idle(1);
        chk("R3 commit clears fraction", 64'(time_ns), 64'd1);
        wr(RA_STEP, BENCH_STEP);
    endtask

    task automatic t_rollover();
        set_time(48'h1_FFFF_FFFF, 30'd999_999_995);
        idle(1);
        chk("R6 wrap sec carry", 64'(time_sec), 64'h2_0000_0000);
        chk("R6 wrap ns", 64'(time_ns), 64'd5);
        set_time(48'd40, 30'd999_999_990);
        idle(1);
        chk("R6 exact second", 64'(time_ns), 64'd0);
        chk("R6 exact second sec", 64'(time_sec), 64'd41);
    endtask

    task automatic t_snapshot();
        logic [31:0] d;
        set_time(48'h2_0000_0003, 30'd999_999_960);
        rd(RA_TIME_NS, d);
        chk("R7 ns read live", 64'(d), 64'd999_999_960);
        idle(5);
        chk("R7 live sec moved", 64'(time_sec), 64'h2_0000_0004);
        rd(RA_SEC_LO, d);
        chk("R7 snapshot lo", 64'(d), 64'd3);
        rd(RA_SEC_HI, d);
        chk("R7 snapshot hi", 64'(d), 64'd2);
    endtask

    task automatic t_alt_window();
        logic [31:0] d;
        logic [29:0] a;
        int exp_ns [5] = '{13, 16, 19, 22, 32};
        wr(RA_ALT_STEP, 32'h30000);    // 3 ns
        wr(RA_TIME_NS, 32'd0);
        wr(RA_ALT_CYCLES, 32'd4);      // this edge still adds 10
        chk("R8 write edge nominal", 64'(time_ns), 64'd10);
        for (int k = 0; k < 5; k++) begin
            idle(1);
            chk("R8 alt window", 64'(time_ns), 64'(exp_ns[k]));
        end
        rd(RA_ALT_CYCLES, d);
        chk("R8 count done", 64'(d), 64'd0);
        wr(RA_ALT_CYCLES, 32'd100);
        idle(10);
        rd(RA_ALT_CYCLES, d);
        chk("R8 countdown readback", 64'(d), 64'd90);
        wr(RA_ALT_CYCLES, 32'd0);
        rd(RA_ALT_CYCLES, d);
        chk("R8 cancel", 64'(d), 64'd0);
        a = time_ns;
        idle(1);
        chk("R8 nominal after cancel", 64'(time_ns), 64'(a) + 64'd10);
    endtask

    task automatic t_drift();
        logic [63:0] acc = 0;
        wr(RA_DRIFT_STEP, 32'h8000);   // 0.5 ns
        wr(RA_DRIFT_GAP, 32'd2);
        wr(RA_TIME_NS, 32'd0);
        for (int k = 1; k <= 6; k++) begin
            idle(1);
            acc += 64'hA0000 + ((k % 2 == 1) ? 64'h8000 : 64'h0);
            chk("R10 drift every 2", 64'(time_ns), acc >> 16);
        end
        wr(RA_DRIFT_GAP, 32'd0);
        wr(RA_TIME_NS, 32'd0);
        idle(6);
        chk("R10 gap zero disables", 64'(time_ns), 64'd60);
    endtask

    task automatic t_rate_ro();
        logic [31:0] d;
        wr(RA_RATE_HZ, 32'h1234);
        rd(RA_RATE_HZ, d);
        chk("R9 rate read-only", 64'(d), 64'(BENCH_HZ));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_commit_stage();
        t_step_readback();
        t_fraction();
        t_rollover();
        t_snapshot();
        t_alt_window();
        t_drift();
        t_rate_ro();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule